// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Controller

This block steers a five-stage pipeline that executes a stream of 16-bit instructions. It owns the program counter and advances it by one instruction (two bytes) per cycle. It detects when the instruction in decode needs a register that a load still in execute has not yet produced. In that case it freezes fetch and sends a bubble into execute. When execute reports a taken branch, it redirects fetch to the branch target and squashes the instruction in decode.

The same unit picks the value each decode-stage source operand should carry into execute. The choice is between the register file, the result the ALU is producing now, and the result held in the memory stage. When more than one producer matches a source register, the newest one wins.

The surrounding datapath supplies register numbers, write-enables, load flags and result buses. It uses the block's outputs as follows: the PC to fetch, `pc_hold` to freeze the fetch/decode register, `ex_ctrl` as the registered control word for execute, and `opnd_a`/`opnd_b` as the operands to latch into execute.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `pc` = 0 and `ex_ctrl` = 0, which is the bubble control word.
- R2: When there is no taken branch and no load-use stall, `pc` increases by 2 at every rising edge.
- R3: `pc_hold` is 1 exactly when all of the following hold in the same cycle: `id_valid` is 1, `ex_wen` is 1, `ex_load` is 1, `ex_dst` equals `id_src_a` or `id_src_b`, and `br_taken` is 0.
- R4: At a rising edge where `pc_hold` is 1, `pc` keeps its value.
- R5: `ex_ctrl` loads 0 at a rising edge where `dec_squash` is 1, and loads `id_ctrl` otherwise. `dec_squash` is 1 when a load-use match (as in R3, but ignoring `br_taken`) or `br_taken` is present.
- R6: At a rising edge where `br_taken` is 1, `pc` loads `br_target`.
- R7: When a load-use match and a taken branch occur in the same cycle, the branch wins. `pc` loads `br_target`, `pc_hold` is 0 and `dec_squash` is 1.
- R8: When `ex_wen` is 1 and `ex_dst` equals a source register, that operand equals `ex_result` and its select output reads 1.
- R9: When the execute stage does not match but `mem_wen` is 1 and `mem_dst` equals the source register, the operand takes the memory-stage value and its select output reads 2. That value is `mem_rdata` if `mem_load` is 1, and `mem_result` otherwise.
- R10: When both the execute and the memory stages match the same source register, the execute-stage result is chosen (select 1).
- R11: A producer whose write-enable is 0 is never forwarded. With no enabled match, the operand equals the register-file value and its select output reads 0.
- R12: `pc` wraps modulo 2^16: stepping from 16'hFFFE gives 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src_a | input | 3 | First source register number in decode |
| id_src_b | input | 3 | Second source register number in decode |
| id_rf_a | input | 16 | Register-file read value for source A |
| id_rf_b | input | 16 | Register-file read value for source B |
| id_ctrl | input | 8 | Control word decoded for the instruction in decode |
| ex_dst | input | 3 | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_result | input | 16 | ALU output of the execute stage |
| mem_dst | input | 3 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | 16 | ALU result held in the memory stage |
| mem_rdata | input | 16 | Data read from memory in the memory stage |
| br_taken | input | 1 | Execute stage resolved a taken branch |
| br_target | input | 16 | Branch target address |
| pc | output | 16 | Program counter used for fetch |
| pc_hold | output | 1 | Freeze fetch and the fetch/decode register (load-use stall) |
| dec_squash | output | 1 | The decode instruction is replaced by a bubble this cycle |
| ex_ctrl | output | 8 | Registered control word entering execute |
| opnd_a | output | 16 | Forwarded operand A |
| opnd_b | output | 16 | Forwarded operand B |
| fwd_sel_a | output | 2 | Source chosen for A: 0 register file, 1 execute, 2 memory |
| fwd_sel_b | output | 2 | Source chosen for B: 0 register file, 1 execute, 2 memory |

## Verification
The bench builds the block with its default parameters: 16-bit data and PC, 3-bit register numbers and an 8-bit control word. The narrow register field matters. Random register numbers then collide often, so execute matches, memory matches, double matches on both operands, and load-use stalls that coincide with taken branches all occur many times in a short run. A 16-bit PC lets a directed branch to 16'hFFFE reach the wrap-around within a few cycles.

// File: rtl/phz_pkg.sv
// Shared types for the pipeline hazard controller.
package phz_pkg;

    // Operand source chosen by a forwarding mux; the encoding is visible at the ports.
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_EX  = 2'd1,
        FWD_MEM = 2'd2
    } fwd_src_e;

endpackage

// File: rtl/phz_pc_seq.sv
// Program counter sequencer.
// Steps by one instruction width each cycle. Holds on a stall and loads the
// target on a redirect. A redirect has priority over a hold.
// Assumes: reset is synchronous and active low; STEP fits in PC_W bits.
module phz_pc_seq #(
    parameter int          PC_W     = 16,
    parameter int          STEP     = 2,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            redirect,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP_V  = PC_W'(STEP);
    localparam logic [PC_W-1:0] RESET_V = PC_W'(RESET_PC);

    // Next-PC selection: reset, redirect, hold, or sequential step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_V;
        else if (redirect)
            pc <= target;
        else if (!hold)
            pc <= pc + STEP_V;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !redirect) |=> (pc == $past(pc) + STEP_V));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !redirect) |=> (pc == $past(pc)));
    p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc == $past(target)));

endmodule

// File: rtl/phz_load_use.sv
// Load-use detector.
// Flags a match when a valid decode instruction reads a register that the
// load currently in execute will write. The value is not available until
// after the memory stage.
// Assumes: sources are packed as NSRC fields of RIDX_W bits.
module phz_load_use #(
    parameter int RIDX_W = 3,
    parameter int NSRC   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        id_valid,
    input  logic [NSRC-1:0][RIDX_W-1:0] src,
    input  logic [RIDX_W-1:0]           ex_dst,
    input  logic                        ex_wen,
    input  logic                        ex_load,
    output logic                        hit
);
    logic [NSRC-1:0] src_match;

    // One comparator per source operand.
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign src_match[g] = (src[g] == ex_dst);
    end

    // Combine per-source matches with the producer qualifiers.
    always_comb begin
        hit = id_valid && ex_wen && ex_load && (|src_match);
    end

    p_hit_needs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (ex_load && ex_wen && id_valid));

endmodule

// File: rtl/phz_fwd_mux.sv
// Operand forwarding mux for one source register.
// Priority is: execute-stage result, then memory-stage value (read data for a
// load, ALU result otherwise), then the register-file value.
// Assumes: a matching load in execute stalls the pipe, so its value is don't-care.
module phz_fwd_mux #(
    parameter int XLEN   = 16,
    parameter int RIDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RIDX_W-1:0]     src,
    input  logic [XLEN-1:0]       rf_data,
    input  logic [RIDX_W-1:0]     ex_dst,
    input  logic                  ex_wen,
    input  logic [XLEN-1:0]       ex_value,
    input  logic [RIDX_W-1:0]     mem_dst,
    input  logic                  mem_wen,
    input  logic                  mem_load,
    input  logic [XLEN-1:0]       mem_alu,
    input  logic [XLEN-1:0]       mem_rdata,
    output phz_pkg::fwd_src_e     sel,
    output logic [XLEN-1:0]       opnd
);
    import phz_pkg::*;

    logic ex_hit;
    logic mem_hit;

    // Producer match, qualified by each stage's write-enable.
    always_comb begin
        ex_hit  = ex_wen  && (ex_dst  == src);
        mem_hit = mem_wen && (mem_dst == src);
    end

    // Priority select, newest producer first.
    always_comb begin
        if (ex_hit)       sel = FWD_EX;
        else if (mem_hit) sel = FWD_MEM;
        else              sel = FWD_RF;
    end

    // Data steering for the selected source.
    always_comb begin
        case (sel)
            FWD_EX:  opnd = ex_value;
            FWD_MEM: opnd = mem_load ? mem_rdata : mem_alu;
            default: opnd = rf_data;
        endcase
    end

    p_ex_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wen && ex_dst == src) |-> (opnd == ex_value));
    p_ex_over_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wen && ex_dst == src && mem_wen && mem_dst == src) |-> (sel == FWD_EX));
    p_no_wen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wen && !mem_wen) |-> (opnd == rf_data));

endmodule

// File: rtl/phz_bubble_reg.sv
// Decode-to-execute control register.
// Loads the decoded control word, or all zeros (a bubble) when squashed.
// Assumes: an all-zero control word performs no architectural action.
module phz_bubble_reg #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              squash,
    input  logic [CTRL_W-1:0] id_ctrl,
    output logic [CTRL_W-1:0] ex_ctrl
);
    // Control-word capture with bubble insertion.
    always_ff @(posedge clk) begin
        if (!rst_n || squash)
            ex_ctrl <= '0;
        else
            ex_ctrl <= id_ctrl;
    end

    p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (ex_ctrl == '0));
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !squash |=> (ex_ctrl == $past(id_ctrl)));

endmodule

// File: rtl/pipe_hazard_ctl.sv
// Pipeline hazard and forwarding controller (top).
// Joins the PC sequencer, the load-use detector, the bubble register and one
// forwarding mux per source operand. A taken branch overrides a load-use
// stall: the PC is redirected and the decode instruction is squashed.
// Assumes: branch resolution and target come from execute in the same cycle.
module pipe_hazard_ctl #(
    parameter int          XLEN     = 16,
    parameter int          PC_W     = 16,
    parameter int          RIDX_W   = 3,
    parameter int          CTRL_W   = 8,
    parameter int          INSTR_W  = 16,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [RIDX_W-1:0] id_src_a,
    input  logic [RIDX_W-1:0] id_src_b,
    input  logic [XLEN-1:0]   id_rf_a,
    input  logic [XLEN-1:0]   id_rf_b,
    input  logic [CTRL_W-1:0] id_ctrl,
    input  logic [RIDX_W-1:0] ex_dst,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [XLEN-1:0]   ex_result,
    input  logic [RIDX_W-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic              mem_load,
    input  logic [XLEN-1:0]   mem_result,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              br_taken,
    input  logic [PC_W-1:0]   br_target,
    output logic [PC_W-1:0]   pc,
    output logic              pc_hold,
    output logic              dec_squash,
    output logic [CTRL_W-1:0] ex_ctrl,
    output logic [XLEN-1:0]   opnd_a,
    output logic [XLEN-1:0]   opnd_b,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b
);
    import phz_pkg::*;

    localparam int NSRC = 2;
    localparam int STEP = INSTR_W / 8;

    logic [NSRC-1:0][RIDX_W-1:0] src_vec;
    logic [NSRC-1:0][XLEN-1:0]   rf_vec;
    logic [NSRC-1:0][XLEN-1:0]   opnd_vec;
    fwd_src_e                    sel_vec [NSRC];
    logic                        lu_hit;

    // Pack per-operand inputs so the forwarding muxes can be generated.
    always_comb begin
        src_vec[0] = id_src_a;
        src_vec[1] = id_src_b;
        rf_vec[0]  = id_rf_a;
        rf_vec[1]  = id_rf_b;
    end

    phz_load_use #(.RIDX_W(RIDX_W), .NSRC(NSRC)) u_lu (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .src(src_vec),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load), .hit(lu_hit)
    );

    // Hazard resolution: a branch overrides the stall and squashes decode.
    always_comb begin
        pc_hold    = lu_hit && !br_taken;
        dec_squash = lu_hit || br_taken;
    end

    phz_pc_seq #(.PC_W(PC_W), .STEP(STEP), .RESET_PC(RESET_PC)) u_pc (
        .clk(clk), .rst_n(rst_n), .hold(pc_hold), .redirect(br_taken),
        .target(br_target), .pc(pc)
    );

    phz_bubble_reg #(.CTRL_W(CTRL_W)) u_bub (
        .clk(clk), .rst_n(rst_n), .squash(dec_squash), .id_ctrl(id_ctrl),
        .ex_ctrl(ex_ctrl)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_fwd
        phz_fwd_mux #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_mux (
            .clk(clk), .rst_n(rst_n), .src(src_vec[g]), .rf_data(rf_vec[g]),
            .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_value(ex_result),
            .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
            .mem_alu(mem_result), .mem_rdata(mem_rdata),
            .sel(sel_vec[g]), .opnd(opnd_vec[g])
        );
    end

    // Unpack forwarded operands and selects onto the ports.
    always_comb begin
        opnd_a    = opnd_vec[0];
        opnd_b    = opnd_vec[1];
        fwd_sel_a = sel_vec[0];
        fwd_sel_b = sel_vec[1];
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == PC_W'(RESET_PC) && ex_ctrl == '0));
    p_branch_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && lu_hit) |-> (!pc_hold && dec_squash));

endmodule

// File: tb/pipe_hazard_ctl_tb_top.sv
// Self-checking bench with a behavioural per-cycle reference model.
module pipe_hazard_ctl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid;
    logic [2:0]  id_src_a, id_src_b, ex_dst, mem_dst;
    logic [15:0] id_rf_a, id_rf_b, ex_result, mem_result, mem_rdata, br_target;
    logic [7:0]  id_ctrl;
    logic        ex_wen, ex_load, mem_wen, mem_load, br_taken;
    logic [15:0] pc, opnd_a, opnd_b;
    logic        pc_hold, dec_squash;
    logic [7:0]  ex_ctrl;
    logic [1:0]  fwd_sel_a, fwd_sel_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state
    int    m_pc;
    int    m_ctrl;
    bit    m_known = 0;
    string pc_tag  = "R1";
    string ctl_tag = "R1";

    pipe_hazard_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src_a(id_src_a),
        .id_src_b(id_src_b), .id_rf_a(id_rf_a), .id_rf_b(id_rf_b), .id_ctrl(id_ctrl),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load), .ex_result(ex_result),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .mem_result(mem_result), .mem_rdata(mem_rdata), .br_taken(br_taken),
        .br_target(br_target), .pc(pc), .pc_hold(pc_hold), .dec_squash(dec_squash),
        .ex_ctrl(ex_ctrl), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected forwarding for one source: returns select, writes value and tag.
    function automatic int fwd_ref(input int src, input int rf,
                                   output int val, output string tag);
        bit eh = ex_wen  && (ex_dst  == src);
        bit mh = mem_wen && (mem_dst == src);
        if (eh) begin
            val = ex_result; tag = mh ? "R10" : "R8"; return 1;
        end
        if (mh) begin
            val = mem_load ? mem_rdata : mem_result; tag = "R9"; return 2;
        end
        val = rf;
        tag = ((ex_dst == src) || (mem_dst == src)) ? "R11" : "R11/R8";
        return 0;
    endfunction

    // One cycle: check registered outputs, drive, check combinational, advance model.
    task automatic cyc(input bit rst, input bit v, input int sa, input int sb,
                       input bit ew, input bit el, input int ed,
                       input bit mw, input bit ml, input int md,
                       input bit br, input int tgt);
        int    va, vb, sela, selb;
        string ta, tb;
        bit    hit;
        @(negedge clk);
        if (m_known) begin
            chk(pc_tag,  int'(pc),      m_pc);
            chk(ctl_tag, int'(ex_ctrl), m_ctrl);
        end
        rst_n = ~rst; id_valid = v; id_src_a = 3'(sa); id_src_b = 3'(sb);
        ex_wen = ew; ex_load = el; ex_dst = 3'(ed);
        mem_wen = mw; mem_load = ml; mem_dst = 3'(md);
        br_taken = br; br_target = 16'(tgt);
        id_rf_a = 16'($urandom); id_rf_b = 16'($urandom); id_ctrl = 8'($urandom);
        ex_result = 16'($urandom); mem_result = 16'($urandom); mem_rdata = 16'($urandom);
        #1;
        hit = v && ew && el && ((ed == sa) || (ed == sb));
        if (!rst) begin
            chk((hit && br) ? "R7" : "R3", int'(pc_hold), int'(hit && !br));
            chk((hit && br) ? "R7" : "R5", int'(dec_squash), int'(hit || br));
            sela = fwd_ref(sa, id_rf_a, va, ta);
            selb = fwd_ref(sb, id_rf_b, vb, tb);
            chk(ta, int'(fwd_sel_a), sela); chk(ta, int'(opnd_a), va);
            chk(tb, int'(fwd_sel_b), selb); chk(tb, int'(opnd_b), vb);
        end
        // Advance the reference model to the state after the next rising edge.
        if (rst) begin
            m_pc = 0; m_ctrl = 0; pc_tag = "R1"; ctl_tag = "R1";
        end else if (br) begin
            m_pc = tgt & 16'hFFFF; pc_tag = hit ? "R7" : "R6";
            m_ctrl = 0; ctl_tag = "R5";
        end else if (hit) begin
            pc_tag = "R4"; m_ctrl = 0; ctl_tag = "R5";
        end else begin
            pc_tag = (m_pc == 16'hFFFE) ? "R12" : "R2";
            m_pc = (m_pc + 2) & 16'hFFFF;
            m_ctrl = int'(id_ctrl); ctl_tag = "R5";
        end
        m_known = 1;
    endtask

    initial begin
        rst_n = 1'b0;
        // Reset (R1)
        repeat (3) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // Plain stepping (R2), no enabled producers (R11)
        repeat (4) cyc(0, 1, 1, 2, 0, 0, 1, 0, 0, 2, 0, 0);
        // Execute forwarding to A (R8), memory ALU forwarding to B (R9)
        cyc(0, 1, 3, 4, 1, 0, 3, 1, 0, 4, 0, 0);
        // Memory load data to A (R9), both stages match B (R10)
        cyc(0, 1, 5, 6, 1, 0, 6, 1, 1, 6, 0, 0);
        cyc(0, 1, 5, 7, 0, 0, 0, 1, 1, 5, 0, 0);
        // Load-use stall (R3, R4), then the same instruction resolved from memory
        cyc(0, 1, 2, 3, 1, 1, 3, 0, 0, 0, 0, 0);
        cyc(0, 1, 2, 3, 0, 0, 0, 1, 1, 3, 0, 0);
        // Load that matches but decode is empty: no stall (R3)
        cyc(0, 0, 2, 3, 1, 1, 2, 0, 0, 0, 0, 0);
        // Taken branch (R6), then branch plus load-use together (R7)
        cyc(0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 16'h0400);
        cyc(0, 1, 1, 2, 1, 1, 1, 0, 0, 0, 1, 16'h0800);
        // Branch to the top of the address space, then wrap (R12)
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFE);
        repeat (3) cyc(0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // Mid-run reset (R1)
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            cyc(0, ($urandom % 8) != 0, int'($urandom % 8), int'($urandom % 8),
                $urandom % 2 == 1, $urandom % 3 == 0, int'($urandom % 8),
                $urandom % 2 == 1, $urandom % 2 == 1, int'($urandom % 8),
                $urandom % 7 == 0, int'($urandom % 65536));
        end
        @(negedge clk);
        chk(pc_tag, int'(pc), m_pc);
        chk(ctl_tag, int'(ex_ctrl), m_ctrl);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule